// File: doc/BRIEF.md
# Programmable 3x3 Colour Space Converter

This block converts a stream of three-channel 10-bit pixels from one colour representation to another. It takes one pixel per clock. Each of the three results is a weighted sum of the three input channels, using nine programmable coefficients. The sum is rounded to an integer, and then a per-channel programmable offset is added. The result is either clamped into the 10-bit range or wrapped modulo 1024, as selected by a saturation control.

A bypass control sends each input channel unchanged to its paired output. The bypass path has the same three-clock latency as the conversion path, so the stream timing does not change when the mode is switched.

Coefficients and offsets are loaded through two simple write ports. Each coefficient has two parts: a 6-bit sign-magnitude whole part and a 10-bit unsigned fraction in units of 1/1024. Each offset is written as one quarter of the amount it adds.

Top module: `csc3x3`

## Requirements
- R1: A coefficient is written as a 6-bit whole part and a 10-bit fraction. Bit 5 of the whole part is the sign. The value is ±(whole[4:0] + fraction/1024), and the sign applies to the whole magnitude.
- R2: A coefficient write with `coef_sel` = 3*o + i sets the weight of input i on output o. The inputs are i=0 red/Cr, i=1 green/Y, i=2 blue/Cb. The outputs are o=0 `out_c1` (Y/G), o=1 `out_c2` (Cb/B), o=2 `out_c3` (Cr/R). Writes with `coef_sel` from 9 to 15 change nothing.
- R3: An offset write with `ofs_sel` = o stores an 8-bit value. Four times that value is added to output o after rounding.
- R4: The full-precision sum of the three products is rounded to the nearest multiple of 1/1024, with halves going toward +infinity, before the offset is added.
- R5: With `sat_en` high, any result below 0 is output as 0 and any result above 1023 is output as 1023.
- R6: With `sat_en` low, the output is the low 10 bits of the two's-complement result.
- R7: With `bypass` high, `out_c1` = `in_g`, `out_c2` = `in_b` and `out_c3` = `in_r`, whatever the coefficients, offsets or `sat_en` are.
- R8: A pixel sampled at clock edge k appears on the outputs after edge k+2, which is three registers later. `out_valid` follows `in_valid` with the same delay, in both modes.
- R9: While `rst_n` is low, `out_valid` and all outputs are 0, and all coefficients and offsets are cleared. A pixel converted before any write therefore gives 0.
- R10: A new pixel is accepted on every clock, including back-to-back valid pixels and pixels with gaps between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | 4 | Coefficient select, 3*output + input |
| coef_int | input | 6 | Sign-magnitude whole part |
| coef_frac | input | 10 | Fraction in 1/1024 units |
| ofs_we | input | 1 | Offset write strobe |
| ofs_sel | input | 2 | Output channel of the offset |
| ofs_val | input | 8 | Offset divided by four |
| bypass | input | 1 | Pass the pixel through unconverted |
| sat_en | input | 1 | Clamp results instead of wrapping |
| in_valid | input | 1 | Input pixel valid |
| in_r | input | 10 | Red / Cr input |
| in_g | input | 10 | Green / Y input |
| in_b | input | 10 | Blue / Cb input |
| out_valid | output | 1 | Output pixel valid |
| out_c1 | output | 10 | Y / G output |
| out_c2 | output | 10 | Cb / B output |
| out_c3 | output | 10 | Cr / R output |

## Verification
On every cycle, the assertions check three things: the three-clock delay of the valid flag, the channel pairing of the bypass path at that same delay, and the cleared state of the outputs as reset is released. The arithmetic can only be shown by the bench's sweeps over pixel grids under several coefficient sets. That arithmetic covers the sign-magnitude decoding, the coefficient indexing, the rounding of halves, the offset scaling and the clamp-versus-wrap choice on overflowing results. Ignored coefficient indices and the cleared coefficients after reset are likewise shown only through converted outputs.

// File: rtl/csc3x3.sv
module csc3x3 #(
  parameter int DW  = 10,
  parameter int IW  = 6,
  parameter int FW  = 10,
  parameter int OFW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           coef_we,
  input  logic [3:0]     coef_sel,
  input  logic [IW-1:0]  coef_int,
  input  logic [FW-1:0]  coef_frac,
  input  logic           ofs_we,
  input  logic [1:0]     ofs_sel,
  input  logic [OFW-1:0] ofs_val,
  input  logic           bypass,
  input  logic           sat_en,
  input  logic           in_valid,
  input  logic [DW-1:0]  in_r,
  input  logic [DW-1:0]  in_g,
  input  logic [DW-1:0]  in_b,
  output logic           out_valid,
  output logic [DW-1:0]  out_c1,
  output logic [DW-1:0]  out_c2,
  output logic [DW-1:0]  out_c3
);
  localparam int CW   = IW + FW;
  localparam int PW   = CW + DW + 1;
  localparam int SW   = PW + 2;
  localparam int HALF = 1 << (FW - 1);
  localparam int MAXV = (1 << DW) - 1;

  logic [IW-1:0]        cint_q  [9];
  logic [FW-1:0]        cfrac_q [9];
  logic [OFW-1:0]       ofs_q   [3];
  logic [DW-1:0]        pin     [3];
  logic signed [PW-1:0] prod_q  [9];
  logic [DW-1:0]        p1_q    [3];
  logic [DW-1:0]        p2_q    [3];
  logic signed [SW-1:0] acc_d   [3];
  logic signed [SW-1:0] acc_q   [3];
  logic [DW-1:0]        res_d   [3];
  logic [DW-1:0]        res_q   [3];
  logic [2:0]           v_q;
  logic [1:0]           byp_q, sat_q;

  function automatic logic signed [CW-1:0] coef_val(input logic [IW-1:0] ip,
                                                    input logic [FW-1:0] fp);
    logic signed [CW-1:0] m;
    m = $signed({1'b0, ip[IW-2:0], fp});
    return ip[IW-1] ? -m : m;
  endfunction

  assign pin[0] = in_r;
  assign pin[1] = in_g;
  assign pin[2] = in_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 9; k++) begin
        cint_q[k]  <= '0;
        cfrac_q[k] <= '0;
      end
      for (int o = 0; o < 3; o++) ofs_q[o] <= '0;
    end else begin
      if (coef_we && coef_sel < 4'd9) begin
        cint_q[coef_sel]  <= coef_int;
        cfrac_q[coef_sel] <= coef_frac;
      end
      if (ofs_we && ofs_sel < 2'd3) ofs_q[ofs_sel] <= ofs_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 9; k++) prod_q[k] <= '0;
      for (int o = 0; o < 3; o++) begin
        p1_q[o]  <= '0;
        p2_q[o]  <= '0;
        acc_q[o] <= '0;
        res_q[o] <= '0;
      end
      v_q   <= '0;
      byp_q <= '0;
      sat_q <= '0;
    end else begin
      for (int k = 0; k < 9; k++)
        prod_q[k] <= PW'(coef_val(cint_q[k], cfrac_q[k])) *
                     PW'($signed({1'b0, pin[k % 3]}));
      for (int o = 0; o < 3; o++) begin
        p1_q[o]  <= pin[o];
        p2_q[o]  <= p1_q[o];
        acc_q[o] <= acc_d[o];
        res_q[o] <= res_d[o];
      end
      v_q   <= {v_q[1:0], in_valid};
      byp_q <= {byp_q[0], bypass};
      sat_q <= {sat_q[0], sat_en};
    end
  end

  always_comb begin
    for (int o = 0; o < 3; o++) begin
      acc_d[o] = SW'(prod_q[3*o]) + SW'(prod_q[3*o+1]) + SW'(prod_q[3*o+2]) + SW'(HALF);
      acc_d[o] = (acc_d[o] >>> FW) + $signed(SW'({ofs_q[o], 2'b00}));
    end
  end

  always_comb begin
    for (int o = 0; o < 3; o++) begin
      if (byp_q[1])
        res_d[o] = p2_q[(o + 1) % 3];
      else if (sat_q[1] && acc_q[o][SW-1])
        res_d[o] = '0;
      else if (sat_q[1] && acc_q[o] > $signed(SW'(MAXV)))
        res_d[o] = DW'(MAXV);
      else
        res_d[o] = acc_q[o][DW-1:0];
    end
  end

  assign out_valid = v_q[2];
  assign out_c1    = res_q[0];
  assign out_c2    = res_q[1];
  assign out_c3    = res_q[2];
endmodule

// File: rtl/csc3x3_chk.sv
module csc3x3_chk #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bypass,
  input logic          in_valid,
  input logic [DW-1:0] in_r,
  input logic [DW-1:0] in_g,
  input logic [DW-1:0] in_b,
  input logic          out_valid,
  input logic [DW-1:0] out_c1,
  input logic [DW-1:0] out_c2,
  input logic [DW-1:0] out_c3
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R8
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R7
  bypass_c1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && $past(bypass, 3) && $past(in_valid, 3)) |-> (out_c1 == $past(in_g, 3)));

  // R7
  bypass_c2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && $past(bypass, 3) && $past(in_valid, 3)) |-> (out_c2 == $past(in_b, 3)));

  // R7
  bypass_c3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && $past(bypass, 3) && $past(in_valid, 3)) |-> (out_c3 == $past(in_r, 3)));

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && out_c1 == '0 && out_c2 == '0 && out_c3 == '0));
endmodule

bind csc3x3 csc3x3_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bypass(bypass), .in_valid(in_valid),
  .in_r(in_r), .in_g(in_g), .in_b(in_b), .out_valid(out_valid),
  .out_c1(out_c1), .out_c2(out_c2), .out_c3(out_c3)
);

// File: tb/csc3x3_bench.sv
`timescale 1ns/1ps
module csc3x3_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       coef_we = 1'b0;
  logic [3:0] coef_sel = '0;
  logic [5:0] coef_int = '0;
  logic [9:0] coef_frac = '0;
  logic       ofs_we = 1'b0;
  logic [1:0] ofs_sel = '0;
  logic [7:0] ofs_val = '0;
  logic       bypass = 1'b0;
  logic       sat_en = 1'b0;
  logic       in_valid = 1'b0;
  logic [9:0] in_r = '0, in_g = '0, in_b = '0;
  logic       out_valid;
  logic [9:0] out_c1, out_c2, out_c3;

  csc3x3 u_csc3x3 (
    .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_sel(coef_sel),
    .coef_int(coef_int), .coef_frac(coef_frac), .ofs_we(ofs_we),
    .ofs_sel(ofs_sel), .ofs_val(ofs_val), .bypass(bypass), .sat_en(sat_en),
    .in_valid(in_valid), .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_c1(out_c1), .out_c2(out_c2), .out_c3(out_c3)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int bi[9], bf[9], bo[3];
  bit e_v[3];
  int e1[3], e2[3], e3[3];
  string e_t[3];
  int grid[10] = '{0, 1, 2, 3, 511, 512, 513, 1021, 1022, 1023};
  int seq = 0;

  function automatic int cv(int k);
    int m;
    m = (bi[k] & 31) * 1024 + bf[k];
    return ((bi[k] >> 5) & 1) ? -m : m;
  endfunction

  function automatic int model(int o, int r, int g, int b);
    int s, t;
    s = cv(3*o) * r + cv(3*o+1) * g + cv(3*o+2) * b;
    t = ((s + 512) >>> 10) + 4 * bo[o];
    if (sat_en) return (t < 0) ? 0 : (t > 1023) ? 1023 : t;
    return t & 1023;
  endfunction

  task automatic cmp(string tag, string nm, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
    end
  endtask

  task automatic step(bit v, int r, int g, int b);
    cmp("R8", "out_valid", int'(out_valid), int'(e_v[2]));
    if (e_v[2]) begin
      cmp(e_t[2], "out_c1", int'(out_c1), e1[2]);
      cmp(e_t[2], "out_c2", int'(out_c2), e2[2]);
      cmp(e_t[2], "out_c3", int'(out_c3), e3[2]);
    end
    for (int s = 2; s > 0; s--) begin
      e_v[s] = e_v[s-1]; e1[s] = e1[s-1]; e2[s] = e2[s-1]; e3[s] = e3[s-1]; e_t[s] = e_t[s-1];
    end
    e_v[0] = v;
    if (bypass) begin
      e1[0] = g; e2[0] = b; e3[0] = r;
    end else begin
      e1[0] = model(0, r, g, b); e2[0] = model(1, r, g, b); e3[0] = model(2, r, g, b);
    end
    in_valid = v; in_r = 10'(r); in_g = 10'(g); in_b = 10'(b);
    @(negedge clk);
  endtask

  task automatic flush();
    for (int k = 0; k < 3; k++) step(1'b0, 0, 0, 0);
  endtask

  task automatic wcoef(int sel, int ip, int fp);
    coef_we = 1'b1; coef_sel = 4'(sel); coef_int = 6'(ip); coef_frac = 10'(fp);
    if (sel < 9) begin bi[sel] = ip; bf[sel] = fp; end
    step(1'b0, 0, 0, 0);
    coef_we = 1'b0;
  endtask

  task automatic wofs(int o, int val);
    ofs_we = 1'b1; ofs_sel = 2'(o); ofs_val = 8'(val);
    bo[o] = val;
    step(1'b0, 0, 0, 0);
    ofs_we = 1'b0;
  endtask

  task automatic load(int ip[9], int fp[9], int o0, int o1, int o2);
    for (int k = 0; k < 9; k++) wcoef(k, ip[k], fp[k]);
    wofs(0, o0); wofs(1, o1); wofs(2, o2);
  endtask

  task automatic sweep(string tag);
    for (int a = 0; a < 10; a++)
      for (int b = 0; b < 10; b++)
        for (int c = 0; c < 10; c++) begin
          seq++;
          e_t[0] = tag;
          step((seq % 7) != 3, grid[a], grid[b], grid[c]);
        end
    flush();
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    for (int k = 0; k < 9; k++) begin bi[k] = 0; bf[k] = 0; end
    for (int o = 0; o < 3; o++) bo[o] = 0;
    for (int s = 0; s < 3; s++) begin e_v[s] = 0; e1[s] = 0; e2[s] = 0; e3[s] = 0; e_t[s] = "R8"; end
    repeat (3) @(negedge clk);
    // R9: state during reset
    cmp("R9", "out_valid", int'(out_valid), 0);
    cmp("R9", "out_c1", int'(out_c1), 0);
    cmp("R9", "out_c2", int'(out_c2), 0);
    cmp("R9", "out_c3", int'(out_c3), 0);
    rst_n = 1'b1;
    sat_en = 1'b1;
    // R9: cleared coefficients and offsets give zero
    sweep("R9");
    // R10: identity matrix, streaming with gaps
    load('{0,1,0, 0,0,1, 1,0,0}, '{0,0,0, 0,0,0, 0,0,0}, 0, 0, 0);
    sweep("R10");
    // R3: mixed-sign matrix with offsets 128 -> +512
    load('{0,0,0, 32,32,0, 0,32,32}, '{218,732,74, 117,395,512, 512,465,47}, 0, 128, 128);
    sweep("R3");
    // R2: writes to indices 9..15 must not alter results
    for (int s = 9; s < 16; s++) wcoef(s, 31, 1023);
    sweep("R2");
    // R1: same set, wrapping
    sat_en = 1'b0;
    flush();
    sweep("R1");
    // R5: overflow and underflow clamped; halves rounded
    sat_en = 1'b1;
    load('{1,1,0, 33,32,0, 0,0,32}, '{512,0,0, 0,512,0, 0,512,512}, 0, 255, 3);
    sweep("R5");
    // R4: same set wrapping, exposing rounding of halves
    sat_en = 1'b0;
    flush();
    sweep("R4");
    // R6: extreme magnitudes, wrapping
    load('{31,0,0, 63,0,0, 0,2,34}, '{1023,0,0, 1023,0,0, 0,0,256}, 255, 0, 100);
    sweep("R6");
    sat_en = 1'b1;
    flush();
    sweep("R5");
    // R7: bypass ignores coefficients, offsets and saturation
    bypass = 1'b1;
    sat_en = 1'b0;
    flush();
    sweep("R7");
    bypass = 1'b0;
    flush();
    report();
  end
endmodule